// File: doc/BRIEF.md
# Dual Interval Timer with Capture and PWM

This block holds two identical counters. Each has its own load register and control/status word, and the two share one interrupt line. A timer in generate mode counts from its load value, up or down. It raises its event flag when the count passes its terminal value, and then either reloads or stops. A timer in capture mode runs freely and copies its count into the load register on each rising edge of its own capture input. The capture input is synchronised inside the block. When both timers are in generate mode with auto-reload and both have PWM enabled, they form one pulse-width output: timer 0 sets the period and timer 1 sets the high time.

Software uses a flat write port and a combinational read port. The address is `{timer, select[1:0]}`:

- select 0 is the control word.
- select 1 is the load register.
- select 2 is the counter, which is read-only.

A freeze input stops every counter while it is high.

Top module: `dual_timer`

## Requirements
- R1: After reset, every control word, load register and counter reads 0, and `irq_o`, `pwm_o` and `gen_o` are low.
- R2: Control bit 3 (LOAD) is stored. While it is set, the counter takes the load register value on every clock and does not count.
- R3: Control bit 4 (RUN) starts the counter. Bit 1 (DOWN) selects down counting (1) or up counting (0). In generate mode (bit 0 = 0), a carry happens when a running counter sits at all-ones (up) or zero (down). This gives a period of MAX-L+1 clocks (up) or L+1 clocks (down) from load value L.
- R4: On a carry, bit 2 (RELOAD) = 1 copies the load value into the counter and counting continues. RELOAD = 0 keeps the counter at its terminal value and clears RUN.
- R5: When bit 6 (GEN) is set, `gen_o[t]` is high for exactly the one clock after each carry of timer t. It never pulses in capture mode.
- R6: In capture mode (bit 0 = 1) with bit 7 (CAPEN) set, a rising edge on `capt_i[t]` copies the counter into the load register and sets the flag. With CAPEN clear, the edge is ignored.
- R7: In capture mode with RELOAD = 0, a captured value is held while the flag is set. With RELOAD = 1, every capture overwrites it.
- R8: Bit 8 (FLAG) reads the event flag. Writing 1 to it clears the flag and writing 0 leaves it unchanged. A new event in the same clock wins over the clear.
- R9: Bit 5 (IRQEN) gates only the output. The flag is set whatever IRQEN holds, and `irq_o` is the OR of flag AND IRQEN over both timers.
- R10: Writing a control word with bit 10 (ALL) set sets RUN in both timers. Bit 10 always reads 0.
- R11: While `freeze_i` is high, no counter changes. After it falls, counting resumes from the held value.
- R12: PWM is active when both timers have bit 9 (PWM) set, are in generate mode and have RELOAD set. In that case a timer 0 carry drives `pwm_o` high and restarts timer 1 from its load value, and the next timer 1 carry drives `pwm_o` low. When PWM is inactive, `pwm_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Write address {timer, select} |
| wr_data_i | input | BUS_W | Write data |
| rd_addr_i | input | 3 | Read address {timer, select} |
| rd_data_o | output | BUS_W | Read data (combinational) |
| capt_i | input | 2 | Asynchronous capture inputs, one per timer |
| freeze_i | input | 1 | Halts all counting while high |
| gen_o | output | 2 | One-clock generate pulses, one per timer |
| irq_o | output | 1 | Combined interrupt |
| pwm_o | output | 1 | Pulse-width modulated output |

## Verification
The counter, flag and generate pulse all update on the clock edge where the carry condition holds. They are therefore visible at the falling edge after that clock. The bench counts edges from the write that set RUN and compares that count with the period formula.

A register write takes effect at the next rising edge. A capture input that rises before edge k loads the register at edge k+2, so the bench waits several clocks after each capture pulse before it reads. PWM transitions follow timer carries on the same edge. All checks read the combinational port a fraction of a nanosecond after a falling edge, so no sample coincides with a rising edge.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
   localparam int CTRL_W   = 11;
   localparam int B_CAPT   = 0;
   localparam int B_DOWN   = 1;
   localparam int B_RELOAD = 2;
   localparam int B_LOAD   = 3;
   localparam int B_RUN    = 4;
   localparam int B_IRQEN  = 5;
   localparam int B_GENEN  = 6;
   localparam int B_CAPEN  = 7;
   localparam int B_FLAG   = 8;
   localparam int B_PWM    = 9;
   localparam int B_ALL    = 10;

   typedef struct packed {
      logic pwm;
      logic capen;
      logic genen;
      logic irqen;
      logic run;
      logic load;
      logic reload;
      logic down;
      logic capt;
   } ctrl_t;

   function automatic ctrl_t to_ctrl(input logic [B_ALL-1:0] w);
      ctrl_t c;
      c.pwm    = w[B_PWM];
      c.capen  = w[B_CAPEN];
      c.genen  = w[B_GENEN];
      c.irqen  = w[B_IRQEN];
      c.run    = w[B_RUN];
      c.load   = w[B_LOAD];
      c.reload = w[B_RELOAD];
      c.down   = w[B_DOWN];
      c.capt   = w[B_CAPT];
      return c;
   endfunction

   function automatic logic [CTRL_W-1:0] from_ctrl(input ctrl_t c, input logic flag);
      logic [CTRL_W-1:0] w;
      w           = '0;
      w[B_PWM]    = c.pwm;
      w[B_CAPEN]  = c.capen;
      w[B_GENEN]  = c.genen;
      w[B_IRQEN]  = c.irqen;
      w[B_RUN]    = c.run;
      w[B_LOAD]   = c.load;
      w[B_RELOAD] = c.reload;
      w[B_DOWN]   = c.down;
      w[B_CAPT]   = c.capt;
      w[B_FLAG]   = flag;
      return w;
   endfunction
endpackage

// File: rtl/dtmr_capsync.sv
module dtmr_capsync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_n_i,
   input  logic async_i,
   output logic rise_o
);
   generate
      if (STAGES < 2 || STAGES > 4) begin : g_bad
         $error("dtmr_capsync: STAGES must be 2..4");
      end
   endgenerate

   logic [STAGES-1:0] sh_q;
   logic              last_q;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         sh_q   <= '0;
         last_q <= 1'b0;
      end else begin
         sh_q   <= {sh_q[STAGES-2:0], async_i};
         last_q <= sh_q[STAGES-1];
      end
   end

   assign rise_o = sh_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/dtmr_chan.sv
module dtmr_chan
   import dtmr_pkg::*;
#(
   parameter int WIDTH = 16
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              ctrl_we_i,
   input  logic [B_ALL-1:0]  ctrl_wdata_i,
   input  logic              load_we_i,
   input  logic [WIDTH-1:0]  load_wdata_i,
   input  logic              run_all_i,
   input  logic              freeze_i,
   input  logic              capt_evt_i,
   input  logic              restart_i,
   output ctrl_t             ctrl_o,
   output logic              flag_o,
   output logic [WIDTH-1:0]  cnt_o,
   output logic [WIDTH-1:0]  load_o,
   output logic              carry_o,
   output logic              gen_o
);
   ctrl_t             ctrl_q, ctrl_d;
   logic              flag_q, flag_d;
   logic [WIDTH-1:0]  cnt_q, load_q, term;
   logic              gen_q;
   logic              counting, carry, capt_hit, take;

   assign counting = ctrl_q.run && !ctrl_q.load && !freeze_i;
   assign term     = ctrl_q.down ? {WIDTH{1'b0}} : {WIDTH{1'b1}};
   assign carry    = counting && !ctrl_q.capt && (cnt_q == term);
   assign capt_hit = ctrl_q.capt && ctrl_q.capen && capt_evt_i;
   assign take     = capt_hit && (ctrl_q.reload || !flag_q);

   always_comb begin
      ctrl_d = ctrl_q;
      if (carry && !ctrl_q.reload) ctrl_d.run = 1'b0;
      if (ctrl_we_i)               ctrl_d = to_ctrl(ctrl_wdata_i);
      if (run_all_i)               ctrl_d.run = 1'b1;
      flag_d = flag_q;
      if (ctrl_we_i && ctrl_wdata_i[B_FLAG]) flag_d = 1'b0;
      if (carry || capt_hit)                 flag_d = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_n_i) begin
         ctrl_q <= '0;
         flag_q <= 1'b0;
         cnt_q  <= '0;
         load_q <= '0;
         gen_q  <= 1'b0;
      end else begin
         ctrl_q <= ctrl_d;
         flag_q <= flag_d;
         gen_q  <= carry && ctrl_q.genen;
         if (load_we_i)  load_q <= load_wdata_i;
         else if (take)  load_q <= cnt_q;
         if (ctrl_q.load || restart_i)  cnt_q <= load_q;
         else if (carry)                cnt_q <= ctrl_q.reload ? load_q : cnt_q;
         else if (counting)             cnt_q <= ctrl_q.down ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
   end

   assign ctrl_o  = ctrl_q;
   assign flag_o  = flag_q;
   assign cnt_o   = cnt_q;
   assign load_o  = load_q;
   assign carry_o = carry;
   assign gen_o   = gen_q;

   // R5
   gen_only_generate_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      gen_q |-> $past(!ctrl_q.capt));
   // R7
   capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (ctrl_q.capt && !ctrl_q.reload && flag_q && !load_we_i) |=> $stable(load_q));
   // R11
   freeze_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (freeze_i && !ctrl_q.load && !restart_i) |=> $stable(cnt_q));
   // R8
   flag_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (carry || capt_hit) |=> flag_q);
endmodule

// File: rtl/dtmr_pwm.sv
module dtmr_pwm
   import dtmr_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_n_i,
   input  ctrl_t ctrl0_i,
   input  ctrl_t ctrl1_i,
   input  logic  carry0_i,
   input  logic  carry1_i,
   output logic  restart1_o,
   output logic  pwm_o
);
   logic active, pwm_q;

   assign active = ctrl0_i.pwm && ctrl1_i.pwm && !ctrl0_i.capt && !ctrl1_i.capt
                   && ctrl0_i.reload && ctrl1_i.reload;
   assign restart1_o = active && carry0_i;

   always_ff @(posedge clk_i) begin
      if (!rst_n_i)       pwm_q <= 1'b0;
      else if (!active)   pwm_q <= 1'b0;
      else if (carry0_i)  pwm_q <= 1'b1;
      else if (carry1_i)  pwm_q <= 1'b0;
   end

   assign pwm_o = pwm_q;

   // R12
   pwm_rise_on_period_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $rose(pwm_q) |-> $past(carry0_i));
   // R12
   pwm_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      $fell(pwm_q) |-> ($past(carry1_i) || !$past(active)));
endmodule

// File: rtl/dual_timer.sv
module dual_timer
   import dtmr_pkg::*;
#(
   parameter int WIDTH       = 16,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_PWM     = 1'b1
) (
   input  logic                                      clk_i,
   input  logic                                      rst_n_i,
   input  logic                                      wr_en_i,
   input  logic [2:0]                                wr_addr_i,
   input  logic [((WIDTH > CTRL_W) ? WIDTH : CTRL_W)-1:0] wr_data_i,
   input  logic [2:0]                                rd_addr_i,
   output logic [((WIDTH > CTRL_W) ? WIDTH : CTRL_W)-1:0] rd_data_o,
   input  logic [1:0]                                capt_i,
   input  logic                                      freeze_i,
   output logic [1:0]                                gen_o,
   output logic                                      irq_o,
   output logic                                      pwm_o
);
   localparam int BUS_W = (WIDTH > CTRL_W) ? WIDTH : CTRL_W;
   localparam int N_TMR = 2;

   generate
      if (WIDTH < 4 || WIDTH > 32) begin : g_bad_width
         $error("dual_timer: WIDTH must be 4..32");
      end
   endgenerate

   ctrl_t            ctrl_w  [N_TMR];
   logic [WIDTH-1:0] cnt_w   [N_TMR];
   logic [WIDTH-1:0] load_w  [N_TMR];
   logic [N_TMR-1:0] flag_w, carry_w, evt_w, irq_src;
   logic             restart1, run_all;

   assign run_all = wr_en_i && (wr_addr_i[1:0] == 2'd0) && wr_data_i[B_ALL];

   for (genvar t = 0; t < N_TMR; t++) begin : g_tmr
      logic is_me;
      assign is_me = wr_en_i && (wr_addr_i[2] == t[0]);

      dtmr_capsync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk_i(clk_i), .rst_n_i(rst_n_i), .async_i(capt_i[t]), .rise_o(evt_w[t]));

      dtmr_chan #(.WIDTH(WIDTH)) u_chan (
         .clk_i        (clk_i),
         .rst_n_i      (rst_n_i),
         .ctrl_we_i    (is_me && (wr_addr_i[1:0] == 2'd0)),
         .ctrl_wdata_i (wr_data_i[B_ALL-1:0]),
         .load_we_i    (is_me && (wr_addr_i[1:0] == 2'd1)),
         .load_wdata_i (wr_data_i[WIDTH-1:0]),
         .run_all_i    (run_all),
         .freeze_i     (freeze_i),
         .capt_evt_i   (evt_w[t]),
         .restart_i    ((t == 1) ? restart1 : 1'b0),
         .ctrl_o       (ctrl_w[t]),
         .flag_o       (flag_w[t]),
         .cnt_o        (cnt_w[t]),
         .load_o       (load_w[t]),
         .carry_o      (carry_w[t]),
         .gen_o        (gen_o[t]));

      assign irq_src[t] = flag_w[t] && ctrl_w[t].irqen;
   end

   generate
      if (HAS_PWM) begin : g_pwm
         dtmr_pwm u_pwm (
            .clk_i(clk_i), .rst_n_i(rst_n_i),
            .ctrl0_i(ctrl_w[0]), .ctrl1_i(ctrl_w[1]),
            .carry0_i(carry_w[0]), .carry1_i(carry_w[1]),
            .restart1_o(restart1), .pwm_o(pwm_o));
      end else begin : g_no_pwm
         assign restart1 = 1'b0;
         assign pwm_o    = 1'b0;
      end
   endgenerate

   assign irq_o = |irq_src;

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i[1:0])
         2'd0:    rd_data_o = BUS_W'(from_ctrl(ctrl_w[rd_addr_i[2]], flag_w[rd_addr_i[2]]));
         2'd1:    rd_data_o = BUS_W'(load_w[rd_addr_i[2]]);
         2'd2:    rd_data_o = BUS_W'(cnt_w[rd_addr_i[2]]);
         default: rd_data_o = '0;
      endcase
   end

   // R9
   irq_needs_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      irq_o |-> (|flag_w));
endmodule

// File: tb/dual_timer_tb.sv
`timescale 1ns/1ps
module dual_timer_tb;
   localparam int W = 16;
   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] wr_addr = '0, rd_addr = '0;
   logic [W-1:0] wr_data = '0, rd_data;
   logic [1:0] capt = '0, gen;
   logic freeze = 1'b0, irq, pwm;
   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   // control bits
   localparam logic [W-1:0] CAPT = 16'h0001, DOWN = 16'h0002, RLD = 16'h0004,
      LOAD = 16'h0008, RUN = 16'h0010, IRQEN = 16'h0020, GENEN = 16'h0040,
      CAPEN = 16'h0080, FLAG = 16'h0100, PWM = 16'h0200, ALL = 16'h0400;

   always #2 clk = ~clk;

   dual_timer u_dut (
      .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
      .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .capt_i(capt), .freeze_i(freeze), .gen_o(gen), .irq_o(irq), .pwm_o(pwm));

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
      rd_addr = a;
      #0.25;
      d = rd_data;
   endtask

   task automatic pulse1();
      @(negedge clk); capt[1] = 1'b1;
      @(negedge clk); @(negedge clk); capt[1] = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   // {timer, down, reload, load, cycles to flag, count after, run after}
   localparam int NV = 5;
   localparam logic [43:0] VEC [NV] = '{
      {1'b0, 1'b0, 1'b1, 16'hFFF0, 8'd16, 16'hFFF0, 1'b1},
      {1'b0, 1'b1, 1'b0, 16'h0005, 8'd6,  16'h0000, 1'b0},
      {1'b1, 1'b0, 1'b0, 16'hFFFA, 8'd6,  16'hFFFF, 1'b0},
      {1'b1, 1'b1, 1'b1, 16'h0009, 8'd10, 16'h0009, 1'b1},
      {1'b0, 1'b0, 1'b1, 16'hFFFF, 8'd1,  16'hFFFF, 1'b1}};

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] v, x, y;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v);
         check("R1 register reset", 32'(v), 0);
      end
      check("R1 outputs low", {29'd0, irq, pwm, |gen}, 0);

      // Table of generate-mode vectors
      for (int i = 0; i < NV; i++) begin
         logic [43:0] e;
         logic [2:0] b;
         logic [W-1:0] mode;
         int n;
         e = VEC[i];
         b = {e[43], 2'b00};
         mode = GENEN | (e[42] ? DOWN : '0) | (e[41] ? RLD : '0);
         wr(b | 3'd1, e[40:25]);
         wr(b, mode | LOAD);
         wr(b, mode | RUN);
         n = 0;
         v = '0;
         while (n < 100 && !v[8]) begin
            @(negedge clk);
            n++;
            rd(b, v);
         end
         check($sformatf("R3 period vec%0d", i), 32'(n), 32'(e[24:17]));
         check($sformatf("R5 gen pulse vec%0d", i), 32'(gen[e[43]]), 1);
         check($sformatf("R4 run after carry vec%0d", i), 32'(v[4]), 32'(e[0]));
         rd(b | 3'd2, x);
         check($sformatf("R4 count after carry vec%0d", i), 32'(x), 32'(e[16:1]));
         if (e[24:17] > 8'd1) begin
            @(negedge clk);
            check($sformatf("R5 gen one cycle vec%0d", i), 32'(gen[e[43]]), 0);
         end
         wr(b, FLAG);
         wr(b, FLAG);
      end

      // R2: LOAD held keeps counter at load value
      wr(3'd1, 16'h0100);
      wr(3'd0, LOAD | RUN);
      repeat (5) @(negedge clk);
      rd(3'd2, v);
      check("R2 load held", 32'(v), 32'h0100);
      wr(3'd0, FLAG);

      // R9 / R8: flag independent of enable, write-0 no effect
      wr(3'd1, 16'hFFFF);
      wr(3'd0, LOAD);
      wr(3'd0, RUN);
      repeat (2) @(negedge clk);
      rd(3'd0, v);
      check("R9 flag set with irq disabled", 32'(v[8]), 1);
      check("R9 irq gated off", 32'(irq), 0);
      wr(3'd0, IRQEN);
      check("R9 irq on when enabled", 32'(irq), 1);
      rd(3'd0, v);
      check("R8 write 0 keeps flag", 32'(v[8]), 1);
      wr(3'd0, IRQEN | FLAG);
      rd(3'd0, v);
      check("R8 write 1 clears flag", 32'(v[8]), 0);
      check("R9 irq off after clear", 32'(irq), 0);
      wr(3'd0, 16'h0000);

      // R11 freeze
      freeze = 1'b1;
      wr(3'd1, 16'h0000);
      wr(3'd0, LOAD);
      wr(3'd0, RUN);
      rd(3'd2, x);
      repeat (5) @(negedge clk);
      rd(3'd2, v);
      check("R11 frozen count stable", 32'(v), 32'(x));
      freeze = 1'b0;
      repeat (3) @(negedge clk);
      rd(3'd2, v);
      check("R11 resumes after freeze", 32'(v), 32'(x + 16'd3));
      wr(3'd0, FLAG);

      // R6 / R7 capture on timer 1, counter frozen for exact values
      freeze = 1'b1;
      wr(3'd5, 16'h1234);
      wr(3'd4, LOAD | FLAG);
      wr(3'd4, CAPT | CAPEN | RUN);
      wr(3'd5, 16'hAAAA);
      pulse1();
      rd(3'd5, v);
      check("R6 capture copies count", 32'(v), 32'h1234);
      rd(3'd4, v);
      check("R6 capture sets flag", 32'(v[8]), 1);
      freeze = 1'b0; repeat (3) @(negedge clk); freeze = 1'b1;
      rd(3'd6, x);
      pulse1();
      rd(3'd5, v);
      check("R7 capture held while flag set", 32'(v), 32'h1234);
      wr(3'd4, CAPT | CAPEN | RUN | FLAG);
      pulse1();
      rd(3'd5, v);
      check("R7 capture after flag clear", 32'(v), 32'(x));
      wr(3'd4, CAPT | CAPEN | RUN | RLD | FLAG);
      freeze = 1'b0; repeat (2) @(negedge clk); freeze = 1'b1;
      pulse1();
      freeze = 1'b0; repeat (2) @(negedge clk); freeze = 1'b1;
      rd(3'd6, y);
      pulse1();
      rd(3'd5, v);
      check("R7 overwrite with reload", 32'(v), 32'(y));
      wr(3'd4, CAPT | RUN | FLAG);
      freeze = 1'b0; repeat (2) @(negedge clk); freeze = 1'b1;
      pulse1();
      rd(3'd5, v);
      check("R6 capture ignored when disabled", 32'(v), 32'(y));
      rd(3'd4, v);
      check("R6 no flag when disabled", 32'(v[8]), 0);
      check("R5 no gen in capture mode", 32'(gen[1]), 0);
      freeze = 1'b0;
      wr(3'd4, FLAG);

      // R10 enable-all
      wr(3'd0, ALL);
      rd(3'd0, v);
      check("R10 timer0 runs", 32'(v[4]), 1);
      check("R10 all bit reads 0", 32'(v[10]), 0);
      rd(3'd4, v);
      check("R10 timer1 runs", 32'(v[4]), 1);
      wr(3'd0, FLAG);
      wr(3'd4, FLAG);

      // R12 PWM: period 10, high 4
      wr(3'd1, 16'hFFF6);
      wr(3'd5, 16'hFFFC);
      wr(3'd0, PWM | RLD | LOAD);
      wr(3'd4, PWM | RLD | LOAD);
      wr(3'd4, PWM | RLD);
      check("R12 pwm low before start", 32'(pwm), 0);
      wr(3'd0, PWM | RLD | ALL);
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         check($sformatf("R12 pwm sample %0d", i), 32'(pwm),
               32'((i >= 10) && ((i % 10) < 4)));
      end
      wr(3'd4, RLD | FLAG);
      @(negedge clk);
      check("R12 pwm low when inactive", 32'(pwm), 0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule